// File: doc/BRIEF.md
# Asynchronous Memory Strobe Timing Engine

This block drives the control strobes, address and write data for one external asynchronous memory region, such as a parallel flash or SRAM. A client issues a single-cycle request that carries a write flag, a byte address and write data. The engine then runs the access in three phases: setup, strobe and hold. The length of each phase is programmable, and reads and writes each have their own set of counts. At the end of the access the engine returns a one-cycle done pulse, and for reads it also returns the data word.

A single control register holds the six timing fields and a bus-width selector that picks a 32-bit or a 16-bit data path. The register may be written at any time. The engine copies the timing for the current access at the moment it accepts a request, so a write to the register during an access only affects later accesses.

Top module: `amem_timing_ctrl`

## Requirements
- R1: After reset, chip enable, output enable and write enable (all active low) are high, and done and busy are low. The control register resets to read 1/21/3 and write 2/13/3 (setup/strobe/hold) with the 32-bit bus selected.
- R2: An accepted request starts its first phase in the next cycle. The setup phase lasts exactly the programmed setup count in cycles. During setup chip enable is low and both output enable and write enable are high.
- R3: The strobe phase follows setup and lasts the programmed strobe count, or 1 cycle when that count is 0. During strobe, output enable is low for reads and write enable is low for writes. The two are never low together.
- R4: The hold phase follows strobe and lasts the programmed hold count. Chip enable stays low through hold and goes high in the cycle after the last hold cycle.
- R5: A setup count of 0 skips the setup phase, and a hold count of 0 skips the hold phase.
- R6: During a write access, the write data is driven and the data-output enable is high for every cycle in which chip enable is low. During a read access, the data-output enable is low.
- R7: Read data is sampled from the memory bus at the end of the last strobe cycle and is held on rd_data until the next read captures new data.
- R8: done is high for exactly one cycle, in the cycle after the access's last cycle. In that cycle chip enable is high and busy is low.
- R9: A request presented while busy is ignored. The memory address stays fixed for the whole access, and no access starts after the current one ends.
- R10: Control-register layout: read setup [3:0], read strobe [9:4], read hold [11:10], write setup [15:12], write strobe [21:16], write hold [23:22], bus width [24] (0 = 32-bit, 1 = 16-bit). The timing and width used by an access are those held when it is accepted.
- R11: In 32-bit mode the memory address is byte address bits [19:2]. In 16-bit mode it is byte address bits [18:1].
- R12: In 16-bit mode, rd_data bits [31:16] read as zero, and mem_wdata bits [31:16] are driven as zero.
- R13: A request presented in the done cycle is accepted, so accesses can run back to back with exactly one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 25 | Control register write value |
| req | input | 1 | Access request, single cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | 18 | Memory word/halfword address |
| mem_wdata | output | 32 | Data driven to memory |
| mem_doe | output | 1 | Data-output enable for the bus driver |
| mem_rdata | input | 32 | Data returned by memory |

## Verification
Two events can fall in the same cycle. The first is the done pulse that ends one access. The second is the acceptance of the next request, which happens in that same done cycle. A second case also needs care: a control-register write can land in the first cycle of an access. The bench provokes both. It raises a request exactly in the done cycle, and it writes new timing while an access is running. It then checks, cycle by cycle, that the current access keeps its old phase lengths and address, and that the next access begins one cycle after done with the new timing. Random accesses with random phase counts, widths and addresses are compared against expected pin patterns. For reads, the bench changes the memory data on every strobe cycle, so a capture on the wrong cycle shows up as a data mismatch.

// File: rtl/amem_pkg.sv
// Package: shared widths, phase encoding and control-register layout for the
// asynchronous memory strobe timing engine.
package amem_pkg;

    parameter int SETUP_W = 4;   // setup count field width
    parameter int STRB_W  = 6;   // strobe count field width
    parameter int HOLD_W  = 2;   // hold count field width

    // Access phase encoding
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    // One direction's timing: setup in the LSBs, then strobe, then hold
    typedef struct packed {
        logic [HOLD_W-1:0]  hold;
        logic [STRB_W-1:0]  strobe;
        logic [SETUP_W-1:0] setup;
    } timing_t;

    // Whole control register: read timing low, write timing above, width on top
    typedef struct packed {
        logic    narrow;
        timing_t wr;
        timing_t rd;
    } cfg_t;

    localparam int CFG_BITS = $bits(cfg_t);

endpackage

// File: rtl/amem_cfg_reg.sv
// Module: amem_cfg_reg
// Holds the packed control register: six timing fields and the bus-width flag.
// Assumes writes may arrive at any time; consumers copy the fields at request
// acceptance, so an update never disturbs an access already running.
module amem_cfg_reg
    import amem_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    output cfg_t                cfg
);

    localparam logic [SETUP_W-1:0] RST_RD_SETUP = SETUP_W'(1);
    localparam logic [STRB_W-1:0]  RST_RD_STRB  = STRB_W'(21);
    localparam logic [HOLD_W-1:0]  RST_RD_HOLD  = HOLD_W'(3);
    localparam logic [SETUP_W-1:0] RST_WR_SETUP = SETUP_W'(2);
    localparam logic [STRB_W-1:0]  RST_WR_STRB  = STRB_W'(13);
    localparam logic [HOLD_W-1:0]  RST_WR_HOLD  = HOLD_W'(3);

    cfg_t cfg_q;

    // Register update: reset to a flash-friendly timing, else load on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.narrow    <= 1'b0;
            cfg_q.rd.setup  <= RST_RD_SETUP;
            cfg_q.rd.strobe <= RST_RD_STRB;
            cfg_q.rd.hold   <= RST_RD_HOLD;
            cfg_q.wr.setup  <= RST_WR_SETUP;
            cfg_q.wr.strobe <= RST_WR_STRB;
            cfg_q.wr.hold   <= RST_WR_HOLD;
        end else if (cfg_we) begin
            cfg_q <= cfg_t'(cfg_wdata);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/amem_phase_fsm.sv
// Module: amem_phase_fsm
// Sequences one access through setup, strobe and hold with a shared down
// counter. Copies the selected timing at start. Zero setup or hold skips that
// phase; a zero strobe count still gives one strobe cycle. Assumes start is
// only raised while the phase is idle.
module amem_phase_fsm
    import amem_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t tim,
    output phase_e  phase,
    output logic    last_strobe,
    output logic    done
);

    localparam int CW0 = (SETUP_W > STRB_W) ? SETUP_W : STRB_W;
    localparam int CW  = (CW0 > HOLD_W) ? CW0 : HOLD_W;

    phase_e          phase_q;
    logic [CW-1:0]   cnt_q;
    timing_t         tim_q;
    logic            done_q;

    // Final counter value for a strobe field; zero is treated as one cycle
    function automatic logic [CW-1:0] strobe_last(input logic [STRB_W-1:0] s);
        return (s == '0) ? '0 : (CW'(s) - CW'(1));
    endfunction

    // Phase sequencing, phase counter and done generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            tim_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        tim_q <= tim;
                        if (tim.setup != '0) begin
                            phase_q <= PH_SETUP;
                            cnt_q   <= CW'(tim.setup) - CW'(1);
                        end else begin
                            phase_q <= PH_STROBE;
                            cnt_q   <= strobe_last(tim.strobe);
                        end
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= strobe_last(tim_q.strobe);
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                PH_STROBE: begin
                    if (cnt_q == '0) begin
                        if (tim_q.hold != '0) begin
                            phase_q <= PH_HOLD;
                            cnt_q   <= CW'(tim_q.hold) - CW'(1);
                        end else begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase       = phase_q;
    assign done        = done_q;
    assign last_strobe = (phase_q == PH_STROBE) && (cnt_q == '0);

    // Strobe is entered only from setup or straight from idle
    assert_strobe_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE && $past(phase_q) != PH_STROBE)
            |-> ($past(phase_q) == PH_SETUP || $past(phase_q) == PH_IDLE));

    // Hold is entered only from strobe
    assert_hold_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && $past(phase_q) != PH_HOLD) |-> $past(phase_q) == PH_STROBE);

    // done is a single-cycle pulse
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // done follows the end of strobe or hold
    assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(phase_q) == PH_HOLD || $past(phase_q) == PH_STROBE));

endmodule

// File: rtl/amem_datapath.sv
// Module: amem_datapath
// Latches direction, mapped address and write data at acceptance, drives them
// for the whole access, and captures read data on the last strobe cycle.
// Assumes accept is only raised while the phase is idle.
module amem_datapath
    import amem_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DW     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              narrow,
    input  phase_e            phase,
    input  logic              last_strobe,
    input  logic [DW-1:0]     mem_rdata,
    output logic              op_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_doe,
    output logic [DW-1:0]     rd_data
);

    localparam int EAW = ADDR_W - 2;
    localparam int HW  = DW / 2;

    logic              we_q;
    logic              narrow_q;
    logic [EAW-1:0]    addr_q;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     rdata_q;
    logic [EAW-1:0]    mapped_addr;
    logic              unused_addr_lsb;

    // Address map: halfword index for the 16-bit bus, word index for 32-bit
    always_comb begin
        mapped_addr = narrow ? req_addr[EAW:1] : req_addr[EAW+1:2];
    end
    assign unused_addr_lsb = req_addr[0];

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            narrow_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
        end else if (accept) begin
            we_q     <= req_we;
            narrow_q <= narrow;
            addr_q   <= mapped_addr;
            wdata_q  <= narrow ? {{(DW-HW){1'b0}}, req_wdata[HW-1:0]} : req_wdata;
        end
    end

    // Read capture at the end of the last strobe cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (last_strobe && !we_q) begin
            rdata_q <= narrow_q ? {{(DW-HW){1'b0}}, mem_rdata[HW-1:0]} : mem_rdata;
        end
    end

    assign op_we     = we_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign mem_doe   = we_q && (phase != PH_IDLE);
    assign rd_data   = rdata_q;

    // Read data changes only after a read's last strobe cycle
    assert_rd_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata_q) |-> $past(last_strobe && !we_q));

    // Address is frozen across consecutive busy cycles
    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(addr_q));

    // In narrow mode the upper data half stays zero
    assert_narrow_upper_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (narrow_q && phase != PH_IDLE) |-> (wdata_q[DW-1:HW] == '0));

endmodule

// File: rtl/amem_timing_ctrl.sv
// Module: amem_timing_ctrl (top)
// Asynchronous memory strobe timing engine for one region. Accepts a request
// when idle, selects read or write timing from the control register, and
// decodes the phase into active-low chip, output and write enables.
// Assumes a single requester; requests while busy are dropped.
module amem_timing_ctrl
    import amem_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DW     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_BITS-1:0] cfg_wdata,
    input  logic                req,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DW-1:0]       req_wdata,
    output logic                busy,
    output logic                done,
    output logic [DW-1:0]       rd_data,
    output logic                mem_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n,
    output logic [ADDR_W-3:0]   mem_addr,
    output logic [DW-1:0]       mem_wdata,
    output logic                mem_doe,
    input  logic [DW-1:0]       mem_rdata
);

    cfg_t    cfg;
    timing_t tim_sel;
    phase_e  phase;
    logic    accept;
    logic    last_strobe;
    logic    op_we;
    logic    in_strobe;

    amem_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    // Acceptance and timing selection by direction
    always_comb begin
        accept  = req && (phase == PH_IDLE);
        tim_sel = req_we ? cfg.wr : cfg.rd;
    end

    amem_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (accept),
        .tim         (tim_sel),
        .phase       (phase),
        .last_strobe (last_strobe),
        .done        (done)
    );

    amem_datapath #(
        .ADDR_W (ADDR_W),
        .DW     (DW)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .narrow      (cfg.narrow),
        .phase       (phase),
        .last_strobe (last_strobe),
        .mem_rdata   (mem_rdata),
        .op_we       (op_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_doe     (mem_doe),
        .rd_data     (rd_data)
    );

    // Strobe decode from the registered phase
    always_comb begin
        in_strobe = (phase == PH_STROBE);
        busy      = (phase != PH_IDLE);
        mem_ce_n  = (phase == PH_IDLE);
        mem_oe_n  = !(in_strobe && !op_we);
        mem_we_n  = !(in_strobe && op_we);
    end

    // Completion is reported with the memory deselected and the engine free
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_ce_n && !busy));

    // An access begins in the cycle after acceptance
    assert_start_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> !mem_ce_n);

    // A request while busy does not extend or restart the access
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && busy && !done) |=> $stable(mem_addr) || $past(done));

endmodule

// File: tb/amem_timing_ctrl_tb.sv
// Bench for amem_timing_ctrl: directed corners plus seeded random accesses,
// each checked cycle by cycle against expected pin patterns.
module amem_timing_ctrl_tb;
    import amem_pkg::*;

    localparam int ADDR_W = 20;
    localparam int DW     = 32;
    localparam int EAW    = ADDR_W - 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                rst_n;
    logic                cfg_we;
    logic [CFG_BITS-1:0] cfg_wdata;
    logic                req, req_we;
    logic [ADDR_W-1:0]   req_addr;
    logic [DW-1:0]       req_wdata;
    logic                busy, done;
    logic [DW-1:0]       rd_data;
    logic                mem_ce_n, mem_oe_n, mem_we_n, mem_doe;
    logic [EAW-1:0]      mem_addr;
    logic [DW-1:0]       mem_wdata, mem_rdata;

    amem_timing_ctrl #(.ADDR_W(ADDR_W), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_doe(mem_doe),
        .mem_rdata(mem_rdata)
    );

    typedef struct {
        int rs, rt, rh, ws, wt, wh;
        bit nar;
    } tcfg_t;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    finished = 0;
    tcfg_t cur;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [CFG_BITS-1:0] enc(input tcfg_t c);
        return {c.nar, 2'(c.wh), 6'(c.wt), 4'(c.ws), 2'(c.rh), 6'(c.rt), 4'(c.rs)};
    endfunction

    function automatic int eff(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    function automatic logic [EAW-1:0] xaddr(input logic [ADDR_W-1:0] a, input bit n);
        return n ? a[EAW:1] : a[EAW+1:2];
    endfunction

    function automatic logic [DW-1:0] pat(input logic [ADDR_W-1:0] a, input int k);
        return {8'(k), 4'h9, a} ^ 32'h3C00_0000;
    endfunction

    function automatic logic [DW-1:0] nmask(input logic [DW-1:0] v, input bit n);
        return n ? {16'h0, v[15:0]} : v;
    endfunction

    task automatic write_cfg(input tcfg_t c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = enc(c);
        @(negedge clk);
        cfg_we = 1'b0;
        cur = c;
    endtask

    // One access, checked every cycle; optional pokes while busy and a
    // back-to-back request raised in the done cycle.
    task automatic access(input bit we, input logic [ADDR_W-1:0] a, input logic [DW-1:0] wd,
                          input string tag, input bit pre, input bit poke_req,
                          input bit poke_cfg, input tcfg_t newc, input bit b2b,
                          input bit nwe, input logic [ADDR_W-1:0] na, input logic [DW-1:0] nwd);
        tcfg_t c;
        int s, te, h, total;
        bit ok, shown;
        logic [DW-1:0] exp_rd;
        c = cur;
        s  = we ? c.ws : c.rs;
        te = eff(we ? c.wt : c.rt);
        h  = we ? c.wh : c.rh;
        total = s + te + h;
        ok = 1'b1; shown = 1'b0;
        if (!pre) begin
            @(negedge clk);
            req = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        end
        @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < total; k++) begin
            bit in_str, cyc_ok;
            in_str = (k >= s) && (k < s + te);
            cyc_ok = (mem_ce_n === 1'b0) && (done === 1'b0) && (busy === 1'b1)
                  && (mem_oe_n === !(in_str && !we)) && (mem_we_n === !(in_str && we))
                  && (mem_addr === xaddr(a, c.nar)) && (mem_doe === we)
                  && (!we || mem_wdata === nmask(wd, c.nar));
            if (!cyc_ok && !shown) begin
                shown = 1'b1;
                $display("  mismatch at access cycle %0d of %0d: ce=%b oe=%b we=%b addr=%h doe=%b",
                         k, total, mem_ce_n, mem_oe_n, mem_we_n, mem_addr, mem_doe);
            end
            ok = ok && cyc_ok;
            if (in_str) mem_rdata = pat(a, k - s);
            if (k == 0 && poke_req) begin
                req = 1'b1; req_we = !we; req_addr = a ^ 20'h0ff0c; req_wdata = ~wd;
            end
            if (k == 0 && poke_cfg) begin
                cfg_we = 1'b1; cfg_wdata = enc(newc);
            end
            @(negedge clk);
            req = 1'b0; cfg_we = 1'b0;
        end
        check(ok, tag, 32'(ok), 32'd1);
        check(done === 1'b1 && mem_ce_n === 1'b1 && busy === 1'b0, "R8 done pulse at end",
              {29'd0, done, mem_ce_n, busy}, 32'd6);
        if (!we) begin
            exp_rd = nmask(pat(a, te - 1), c.nar);
            check(rd_data === exp_rd, "R7 read capture on last strobe", rd_data, exp_rd);
        end
        if (poke_cfg) cur = newc;
        if (b2b) begin
            req = 1'b1; req_we = nwe; req_addr = na; req_wdata = nwd;
        end else begin
            @(negedge clk);
            check(done === 1'b0, "R8 done lasts one cycle", 32'(done), 32'd0);
            if (poke_req) begin
                for (int j = 0; j < 3; j++) begin
                    check(mem_ce_n === 1'b1 && busy === 1'b0, "R9 dropped request starts nothing",
                          {30'd0, mem_ce_n, busy}, 32'd2);
                    @(negedge clk);
                end
            end
        end
    endtask

    task automatic simple(input bit we, input logic [ADDR_W-1:0] a, input logic [DW-1:0] wd, input string tag);
        access(we, a, wd, tag, 1'b0, 1'b0, 1'b0, cur, 1'b0, 1'b0, '0, '0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tcfg_t c;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req = 1'b0; req_we = 1'b0;
        req_addr = '0; req_wdata = '0; mem_rdata = '0;
        cur = '{rs:1, rt:21, rh:3, ws:2, wt:13, wh:3, nar:1'b0};
        repeat (3) @(negedge clk);
        // R1: idle outputs while in reset
        check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1 strobes high in reset",
              {29'd0, mem_ce_n, mem_oe_n, mem_we_n}, 32'd7);
        check(done === 1'b0 && busy === 1'b0, "R1 done and busy low in reset", {30'd0, done, busy}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_ce_n === 1'b1 && busy === 1'b0, "R1 idle after reset", {30'd0, mem_ce_n, busy}, 32'd2);

        // R1 reset timing, R2/R3/R4 phase order and lengths
        simple(1'b0, 20'h12344, 32'h0, "R1 R2 R3 R4 default read timing");
        simple(1'b1, 20'h0abc8, 32'hdead_beef, "R6 default write timing and data drive");

        // R5 zero setup and hold, R3 zero strobe gives one cycle
        write_cfg('{rs:0, rt:0, rh:0, ws:0, wt:0, wh:0, nar:1'b0});
        simple(1'b0, 20'h00010, 32'h0, "R5 R3 all-zero read");
        simple(1'b1, 20'h00020, 32'h1234_5678, "R5 R3 all-zero write");
        write_cfg('{rs:0, rt:4, rh:2, ws:3, wt:2, wh:0, nar:1'b0});
        simple(1'b0, 20'h00404, 32'h0, "R5 zero setup read");
        simple(1'b1, 20'h00408, 32'h0f0f_0f0f, "R5 zero hold write");

        // R2 maximum field values
        write_cfg('{rs:15, rt:63, rh:3, ws:15, wt:63, wh:3, nar:1'b0});
        simple(1'b0, 20'hfffff, 32'h0, "R2 R10 maximum read fields");
        simple(1'b1, 20'hffffc, 32'h8000_0001, "R2 R10 maximum write fields");

        // R11 R12 narrow bus
        write_cfg('{rs:1, rt:3, rh:1, ws:2, wt:2, wh:1, nar:1'b1});
        simple(1'b0, 20'h5a5a6, 32'h0, "R11 R12 narrow read");
        simple(1'b1, 20'h3c3c3, 32'hcafe_f00d, "R11 R12 narrow write");

        // R9 request while busy is dropped
        write_cfg('{rs:2, rt:3, rh:2, ws:1, wt:4, wh:1, nar:1'b0});
        access(1'b0, 20'h01230, 32'h0, "R9 busy read ignores request", 1'b0, 1'b1, 1'b0, cur,
               1'b0, 1'b0, '0, '0);

        // R10 timing captured at acceptance; new timing applies to the next access
        c = '{rs:0, rt:5, rh:1, ws:3, wt:1, wh:2, nar:1'b1};
        access(1'b0, 20'h04444, 32'h0, "R10 old timing kept during access", 1'b0, 1'b0, 1'b1, c,
               1'b0, 1'b0, '0, '0);
        simple(1'b0, 20'h04446, 32'h0, "R10 new timing on next access");

        // R13 request in the done cycle
        write_cfg('{rs:1, rt:2, rh:1, ws:1, wt:2, wh:0, nar:1'b0});
        access(1'b1, 20'h00100, 32'h1111_2222, "R13 first of back-to-back", 1'b0, 1'b0, 1'b0, cur,
               1'b1, 1'b0, 20'h00200, 32'h0);
        access(1'b0, 20'h00200, 32'h0, "R13 accepted in done cycle", 1'b1, 1'b0, 1'b0, cur,
               1'b0, 1'b0, '0, '0);

        // Random accesses with random timing and width
        for (int i = 0; i < 40; i++) begin
            if (i % 4 == 0) begin
                c.rs = (($urandom % 8) == 0) ? 15 : int'($urandom % 4);
                c.rt = int'($urandom % 9);
                c.rh = int'($urandom % 4);
                c.ws = int'($urandom % 4);
                c.wt = int'($urandom % 9);
                c.wh = int'($urandom % 4);
                c.nar = 1'($urandom % 2);
                write_cfg(c);
            end
            simple(1'($urandom % 2), 20'($urandom), 32'($urandom), "R2 R3 R4 R6 R11 random access");
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule